// File: doc/BRIEF.md
# Segment Address Translation Unit

This unit turns a segment selector and an offset into a linear address, as a segmented protected-mode processor does. The selector names one descriptor in one of two internal descriptor tables, a global table or a local table. The descriptor gives a base, a limit, a granularity flag, a present flag and an executable flag. The unit adds the offset to the base. It checks that every byte of the access lies inside the segment, and it refuses instruction fetches from segments that are not executable.

Software, or the surrounding pipeline, fills both tables through a single write port. A request strobe with selector, offset, access size and access type produces one registered result in the following cycle. That result is either a valid linear address or a fault code. Segments are independent: they may overlap or coincide, and nothing compares them.

Top module: `seg_xlate`

## Requirements
- R1: Selector bits [15:3] are the descriptor index and bit [2] selects the table (1 = local, 0 = global); bits [1:0] have no effect on the result.
- R2: One cycle after `req` is high, either `out_valid` is 1 with `out_addr` = base + offset modulo 2^32, or a fault code is shown.
- R3: Global index 0 is a null descriptor: any request through it yields fault code 1, whatever has been written to that slot.
- R4: A descriptor whose present flag is 0 yields fault code 2; after reset every descriptor is absent.
- R5: An access of type 2 (instruction fetch) through a descriptor whose executable flag is 0 yields fault code 4; types 0 (read), 1 (write) and 3 (treated as read) do not depend on that flag.
- R6: With granularity 0 the effective limit is the 20-bit limit field in bytes. If offset + bytes − 1 exceeds it, the result is fault code 3. `acc_size` codes 0..3 mean 1, 2, 4 and 8 bytes.
- R7: With granularity 1 the effective limit is the limit field shifted left by 12 with the low 12 bits set to ones.
- R8: If offset + bytes − 1 carries out of 32 bits, the result is fault code 3, even when the effective limit is 0xFFFFFFFF.
- R9: An index at or above the configured depth of the addressed table yields fault code 5.
- R10: When several faults apply, the code reported follows this priority: 5, then 1, then 2, then 4, then 3.
- R11: `out_valid` and a nonzero `out_fault` are never both shown. On a fault, `out_addr` is 0. A cycle without `req` gives `out_valid` = 0 and `out_fault` = 0 in the next cycle.
- R12: A table write affects requests from the next cycle onward. A request in the same cycle as a write to its descriptor sees the old contents. A write to an index at or above the table depth changes nothing.
- R13: While `rst` is high and in the cycle after, `out_valid`, `out_fault` and `out_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one descriptor this cycle |
| wr_local | input | 1 | Write target table: 1 local, 0 global |
| wr_index | input | 13 | Descriptor slot to write |
| wr_base | input | 32 | Segment base to store |
| wr_limit | input | 20 | Limit field to store |
| wr_gran | input | 1 | Granularity flag: 1 = 4 KiB units |
| wr_present | input | 1 | Present flag |
| wr_exec | input | 1 | Executable flag |
| req | input | 1 | Translation request strobe |
| selector | input | 16 | Segment selector |
| offset | input | 32 | Offset within the segment |
| acc_size | input | 2 | Access bytes: 1 << acc_size |
| acc_type | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| out_valid | output | 1 | Linear address is valid |
| out_addr | output | 32 | Linear address (0 on fault) |
| out_fault | output | 3 | 0 none, 1 null, 2 absent, 3 limit, 4 not executable, 5 index out of range |

## Verification
A descriptor write and a translation request can land in the same cycle, both aimed at the same slot. The bench provokes this directly: it requests through an absent local descriptor while writing a present one into that slot. It expects the absent fault, and then a valid address on the next request. The random phase mixes writes and requests freely, and the reference model applies each write only after the cycle's request has been predicted, so any premature forwarding in the design shows up as a mismatch.

// File: rtl/seg_pkg.sv
package seg_pkg;

    localparam int SEL_W  = 16;
    localparam int IDX_W  = 13;
    localparam int ADDR_W = 32;
    localparam int LIM_W  = 20;
    localparam int FLT_W  = 3;

    typedef enum logic [FLT_W-1:0] {
        FLT_NONE   = 3'd0,
        FLT_NULL   = 3'd1,
        FLT_ABSENT = 3'd2,
        FLT_BOUND  = 3'd3,
        FLT_NOEXEC = 3'd4,
        FLT_RANGE  = 3'd5
    } fault_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_OTHER = 2'd3
    } acc_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [LIM_W-1:0]  limit;
        logic              gran;
        logic              present;
        logic              exec;
    } desc_t;

    typedef struct packed {
        logic [IDX_W-1:0] index;
        logic             local_tbl;
    } sel_t;

    function automatic sel_t split_sel(input logic [SEL_W-1:0] s);
        sel_t r;
        r.index     = s[SEL_W-1:3];
        r.local_tbl = s[2];
        return r;
    endfunction

    function automatic logic [ADDR_W-1:0] eff_limit(input desc_t d);
        return d.gran ? {d.limit, 12'hFFF} : {12'h000, d.limit};
    endfunction

    function automatic logic [3:0] size_bytes(input logic [1:0] code);
        return 4'd1 << code;
    endfunction

endpackage

// File: rtl/seg_table.sv
module seg_table
    import seg_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_index,
    input  desc_t            wr_desc,
    input  logic [IDX_W-1:0] rd_index,
    output desc_t            rd_desc,
    output logic             rd_hit
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [IDX_W-1:0] DEPTH_L = IDX_W'(DEPTH);

    desc_t mem [DEPTH];

    logic wr_hit;
    assign wr_hit = wr_en && (wr_index < DEPTH_L);
    assign rd_hit = rd_index < DEPTH_L;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_hit) begin
            mem[wr_index[AW-1:0]] <= wr_desc;
        end
    end

    always_comb begin
        rd_desc = '0;
        if (rd_hit) rd_desc = mem[rd_index[AW-1:0]];
    end

endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_pkg::*;
(
    input  desc_t             desc,
    input  logic              in_range,
    input  logic              is_null,
    input  logic [ADDR_W-1:0] offset,
    input  logic [1:0]        acc_size,
    input  acc_e              acc,
    output fault_e            fault,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W:0]   last_byte;
    logic [ADDR_W-1:0] lim;
    logic              over;

    always_comb begin
        last_byte = {1'b0, offset} + (ADDR_W+1)'(size_bytes(acc_size)) - 33'd1;
        lim       = eff_limit(desc);
        over      = last_byte[ADDR_W] || (last_byte[ADDR_W-1:0] > lim);

        if (!in_range)                              fault = FLT_RANGE;
        else if (is_null)                           fault = FLT_NULL;
        else if (!desc.present)                     fault = FLT_ABSENT;
        else if (acc == ACC_FETCH && !desc.exec)    fault = FLT_NOEXEC;
        else if (over)                              fault = FLT_BOUND;
        else                                        fault = FLT_NONE;

        addr = (fault == FLT_NONE) ? desc.base + offset : '0;
    end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_pkg::*;
#(
    parameter int GDT_DEPTH = 16,
    parameter int LDT_DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        wr_local,
    input  logic [12:0] wr_index,
    input  logic [31:0] wr_base,
    input  logic [19:0] wr_limit,
    input  logic        wr_gran,
    input  logic        wr_present,
    input  logic        wr_exec,
    input  logic        req,
    input  logic [15:0] selector,
    input  logic [31:0] offset,
    input  logic [1:0]  acc_size,
    input  logic [1:0]  acc_type,
    output logic        out_valid,
    output logic [31:0] out_addr,
    output logic [2:0]  out_fault
);
    localparam int NUM_TBL = 2;

    desc_t  wdesc;
    sel_t   sel;
    desc_t  tbl_desc [NUM_TBL];
    logic   tbl_hit  [NUM_TBL];
    desc_t  cur_desc;
    logic   cur_hit;
    logic   null_sel;
    fault_e chk_fault;
    logic [ADDR_W-1:0] chk_addr;

    assign wdesc = '{base: wr_base, limit: wr_limit, gran: wr_gran,
                     present: wr_present, exec: wr_exec};
    assign sel   = split_sel(selector);

    // table 0 = global, table 1 = local
    for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
        localparam int D = (t == 0) ? GDT_DEPTH : LDT_DEPTH;
        seg_table #(.DEPTH(D)) u_tbl (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (wr_en && (wr_local == 1'(t))),
            .wr_index (wr_index),
            .wr_desc  (wdesc),
            .rd_index (sel.index),
            .rd_desc  (tbl_desc[t]),
            .rd_hit   (tbl_hit[t])
        );
    end

    assign cur_desc = sel.local_tbl ? tbl_desc[1] : tbl_desc[0];
    assign cur_hit  = sel.local_tbl ? tbl_hit[1]  : tbl_hit[0];
    assign null_sel = !sel.local_tbl && (sel.index == '0);

    seg_check u_chk (
        .desc     (cur_desc),
        .in_range (cur_hit),
        .is_null  (null_sel),
        .offset   (offset),
        .acc_size (acc_size),
        .acc      (acc_e'(acc_type)),
        .fault    (chk_fault),
        .addr     (chk_addr)
    );

    always_ff @(posedge clk) begin
        if (rst || !req) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_fault <= FLT_NONE;
        end else begin
            out_valid <= (chk_fault == FLT_NONE);
            out_addr  <= chk_addr;
            out_fault <= chk_fault;
        end
    end

    AST_VALID_FAULT_EXCL: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_fault == FLT_NONE)); // R11
    AST_FAULT_ADDR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_fault != FLT_NONE) |-> (out_addr == '0)); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req |=> (!out_valid && out_fault == FLT_NONE)); // R11
    AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (rst)
        req |=> (out_valid || out_fault != FLT_NONE)); // R2
    AST_NULL_SLOT: assert property (@(posedge clk) disable iff (rst)
        (req && null_sel) |=> (out_fault == FLT_NULL)); // R3
    AST_FETCH_NOEXEC: assert property (@(posedge clk) disable iff (rst)
        (req && cur_hit && !null_sel && cur_desc.present && !cur_desc.exec
         && acc_type == ACC_FETCH) |=> (out_fault == FLT_NOEXEC)); // R5
    AST_ABSENT: assert property (@(posedge clk) disable iff (rst)
        (req && cur_hit && !null_sel && !cur_desc.present)
        |=> (out_fault == FLT_ABSENT)); // R4

endmodule

// File: tb/test_seg_xlate.sv
module test_seg_xlate;
    import seg_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DEP = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, wr_local, wr_gran, wr_present, wr_exec;
    logic [12:0] wr_index;
    logic [31:0] wr_base;
    logic [19:0] wr_limit;
    logic        req;
    logic [15:0] selector;
    logic [31:0] offset;
    logic [1:0]  acc_size, acc_type;
    logic        out_valid;
    logic [31:0] out_addr;
    logic [2:0]  out_fault;

    int n_cmp = 0;
    int n_mis = 0;
    bit done = 0;

    desc_t gm [DEP];
    desc_t lm [DEP];

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_xlate i_seg_xlate (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_local(wr_local),
        .wr_index(wr_index), .wr_base(wr_base), .wr_limit(wr_limit),
        .wr_gran(wr_gran), .wr_present(wr_present), .wr_exec(wr_exec),
        .req(req), .selector(selector), .offset(offset),
        .acc_size(acc_size), .acc_type(acc_type),
        .out_valid(out_valid), .out_addr(out_addr), .out_fault(out_fault)
    );

    function automatic void predict(input logic [15:0] s, input logic [31:0] off,
                                    input logic [1:0] sz, input logic [1:0] at,
                                    output logic [2:0] f, output logic [31:0] a);
        int idx = int'(s[15:3]);
        bit loc = s[2];
        desc_t d;
        longint lastb, lim;
        a = 0;
        if (idx >= DEP) begin f = 3'd5; return; end
        if (!loc && idx == 0) begin f = 3'd1; return; end
        d = loc ? lm[idx] : gm[idx];
        if (!d.present) begin f = 3'd2; return; end
        if (at == 2'd2 && !d.exec) begin f = 3'd4; return; end
        lastb = longint'(off) + (longint'(1) << sz) - 1;
        lim = d.gran ? (longint'(d.limit) * 4096 + 4095) : longint'(d.limit);
        if (lastb > 64'hFFFF_FFFF || lastb > lim) begin f = 3'd3; return; end
        f = 3'd0;
        a = d.base + off;
    endfunction

    function automatic string tag_of(input logic [2:0] f);
        case (f)
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R6";
            3'd4: return "R5";
            3'd5: return "R9";
            default: return "R2";
        endcase
    endfunction

    task automatic check(input string tag, input logic ev, input logic [2:0] ef,
                         input logic [31:0] ea);
        n_cmp++;
        if (out_valid !== ev || out_fault !== ef || out_addr !== ea) begin
            n_mis++;
            $display("FAIL %s: got valid=%0b fault=%0d addr=%h, expected valid=%0b fault=%0d addr=%h",
                     tag, out_valid, out_fault, out_addr, ev, ef, ea);
        end
    endtask

    // One cycle: optional write and optional request applied together.
    task automatic cycle(input string tag, input bit rq, input logic [15:0] s,
                         input logic [31:0] off, input logic [1:0] sz, input logic [1:0] at,
                         input bit w, input bit wl, input logic [12:0] wi, input desc_t wd);
        logic [2:0]  ef;
        logic [31:0] ea;
        @(negedge clk);
        req = rq; selector = s; offset = off; acc_size = sz; acc_type = at;
        wr_en = w; wr_local = wl; wr_index = wi;
        wr_base = wd.base; wr_limit = wd.limit; wr_gran = wd.gran;
        wr_present = wd.present; wr_exec = wd.exec;
        if (rq) predict(s, off, sz, at, ef, ea);
        else begin ef = 3'd0; ea = 32'd0; end
        @(posedge clk);
        if (w && wi < DEP) begin
            if (wl) lm[wi] = wd; else gm[wi] = wd;
        end
        #1;
        check((tag == "") ? tag_of(ef) : tag, rq && ef == 3'd0, ef, ea);
    endtask

    task automatic wr(input bit wl, input logic [12:0] wi, input logic [31:0] b,
                      input logic [19:0] l, input bit g, input bit p, input bit x);
        desc_t d;
        d = '{base: b, limit: l, gran: g, present: p, exec: x};
        cycle("R12", 0, 16'h0, 32'h0, 2'd0, 2'd0, 1, wl, wi, d);
    endtask

    task automatic rq(input string tag, input logic [15:0] s, input logic [31:0] off,
                      input logic [1:0] sz, input logic [1:0] at);
        cycle(tag, 1, s, off, sz, at, 0, 0, 13'd0, '0);
    endtask

    function automatic logic [15:0] mksel(input int idx, input bit loc, input logic [1:0] lo);
        return {13'(idx), loc, lo};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_mis++;
            $display("FAIL watchdog: got no finish, expected finish before timeout");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < DEP; i++) begin gm[i] = '0; lm[i] = '0; end
        rst = 1; req = 0; wr_en = 0; wr_local = 0; wr_index = 0; wr_base = 0;
        wr_limit = 0; wr_gran = 0; wr_present = 0; wr_exec = 0;
        selector = 0; offset = 0; acc_size = 0; acc_type = 0;
        repeat (3) @(posedge clk);
        #1 check("R13", 0, 3'd0, 32'd0);
        @(negedge clk); rst = 0;

        // R13/R4: everything absent after reset
        rq("R4", mksel(3, 0, 2'd0), 32'h0, 2'd0, 2'd0);
        rq("R4", mksel(3, 1, 2'd0), 32'h0, 2'd0, 2'd0);

        // R3: null slot faults even when written present
        wr(0, 0, 32'h100, 20'hFFFFF, 1, 1, 1);
        rq("R3", mksel(0, 0, 2'd3), 32'h0, 2'd0, 2'd0);

        // R6/R1: byte granularity bounds
        wr(1, 2, 32'h0000_1000, 20'h000FF, 0, 1, 0);
        rq("R6", mksel(2, 1, 2'd0), 32'h0000_00FC, 2'd2, 2'd0);
        rq("R6", mksel(2, 1, 2'd0), 32'h0000_00FD, 2'd2, 2'd1);
        rq("R1", mksel(2, 1, 2'd3), 32'h0000_0010, 2'd0, 2'd3);
        rq("R1", mksel(2, 0, 2'd0), 32'h0000_0010, 2'd0, 2'd0);
        // R5: fetch refused from data segment, allowed from code segment
        rq("R5", mksel(2, 1, 2'd0), 32'h0000_0010, 2'd0, 2'd2);
        wr(0, 9, 32'h2000_0000, 20'h00FFF, 0, 1, 1);
        rq("R5", mksel(9, 0, 2'd0), 32'h0000_0FF8, 2'd3, 2'd2);

        // R7: 4 KiB granularity
        wr(0, 5, 32'h0, 20'h00001, 1, 1, 0);
        rq("R7", mksel(5, 0, 2'd0), 32'h0000_1FFF, 2'd0, 2'd0);
        rq("R7", mksel(5, 0, 2'd0), 32'h0000_1FFE, 2'd2, 2'd0);

        // R8: carry out at top of 4 GiB segment, R2 wrap of base + offset
        wr(0, 6, 32'h0000_0010, 20'hFFFFF, 1, 1, 0);
        rq("R2", mksel(6, 0, 2'd0), 32'hFFFF_FFFC, 2'd2, 2'd0);
        rq("R8", mksel(6, 0, 2'd0), 32'hFFFF_FFFD, 2'd2, 2'd0);
        rq("R8", mksel(6, 0, 2'd0), 32'hFFFF_FFF9, 2'd3, 2'd1);

        // R9 and ignored out-of-range write (R12)
        wr(0, 20, 32'hDEAD_0000, 20'hFFFFF, 0, 1, 1);
        rq("R9", mksel(20, 0, 2'd0), 32'h0, 2'd0, 2'd0);
        rq("R12", mksel(4, 0, 2'd0), 32'h0, 2'd0, 2'd0);
        rq("R9", mksel(16, 1, 2'd0), 32'h0, 2'd0, 2'd0);

        // R10 priority
        rq("R10", mksel(0, 0, 2'd0), 32'hFFFF_FFFF, 2'd3, 2'd2);
        wr(1, 3, 32'h0, 20'h0, 0, 0, 0);
        rq("R10", mksel(3, 1, 2'd0), 32'hFFFF_0000, 2'd0, 2'd2);
        rq("R10", mksel(2, 1, 2'd0), 32'h0000_0FFF, 2'd0, 2'd2);

        // R12: write and request to the same slot in one cycle
        cycle("R12", 1, mksel(7, 1, 2'd0), 32'h4, 2'd0, 2'd0,
              1, 1, 13'd7, '{base: 32'h0000_8000, limit: 20'h00010, gran: 1'b0,
                              present: 1'b1, exec: 1'b0});
        rq("R12", mksel(7, 1, 2'd0), 32'h4, 2'd0, 2'd0);

        // R11: idle cycle
        cycle("R11", 0, mksel(7, 1, 2'd0), 32'h4, 2'd0, 2'd0, 0, 0, 13'd0, '0);

        // Random mix of writes and requests
        for (int n = 0; n < 600; n++) begin
            bit do_w = ($urandom % 4) == 0;
            bit do_r = ($urandom % 5) != 0;
            bit wl = $urandom % 2;
            logic [12:0] wi = 13'($urandom % 18);
            desc_t d;
            int ri = $urandom % 18;
            bit rl = $urandom % 2;
            desc_t t;
            logic [31:0] off;
            logic [31:0] lim;
            d.base = $urandom;
            d.limit = ($urandom % 2) ? 20'($urandom % 256) : 20'($urandom);
            d.gran = $urandom % 2;
            d.present = ($urandom % 5) != 0;
            d.exec = $urandom % 2;
            t = (ri < DEP) ? (rl ? lm[ri] : gm[ri]) : '0;
            lim = t.gran ? {t.limit, 12'hFFF} : {12'h0, t.limit};
            off = ($urandom % 4 == 0) ? $urandom : lim - 32'($urandom % 12) + 32'd2;
            cycle("", do_r, mksel(ri, rl, 2'($urandom)), off, 2'($urandom), 2'($urandom),
                  do_w, wl, wi, d);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end

endmodule